// File: doc/BRIEF.md
# Audio Frame and Bit Clock Generator

This block turns one master clock into the two timing clocks of an audio serial port: a frame clock that marks left and right channel halves, and a bit clock that shifts the sample bits. Each frame holds exactly 64 bit-clock periods. A two-bit speed code sets the frame length to 256, 128 or 64 internal clock cycles. An optional prescaler halves the master clock before any of these ratios apply.

In master operation the block drives both clocks. It also gives a strobe at the start of every frame, where the frame clock goes low and the left channel begins. In slave operation it stops generating clocks and passes clocks that arrive from outside straight through to its outputs. While the active-low reset is held, the block stays in power-down with every output static and low. A configuration-error flag reports the reserved speed code, and it also reports a prescaler request made in slave operation.

Top module: `audio_clkgen`

## Requirements
- R1: With `halve_en`=0 in master operation, `frame_clk` has a period of 256, 128 or 64 `mclk` cycles for `speed_sel` 00, 01 or 10. It is low for the first half of each frame and high for the second half.
- R2: `bit_clk` has a period of one sixty-fourth of the frame, which is 4, 2 or 1 internal cycles. It is low for the first half of each of its periods. When its period is one `mclk` cycle, `bit_clk` is the inverted master clock: low while `mclk` is high and high while `mclk` is low.
- R3: With `halve_en`=1 in master operation, every period from R1 and R2 becomes twice as long, counted in `mclk` cycles.
- R4: `frame_clk` changes level only at an `mclk` edge where `bit_clk` goes from 1 to 0.
- R5: `frame_start` is high during the first internal cycle of every frame: one `mclk` cycle, or two when halved. At those times `frame_clk` is low. `frame_start` is low at all other times.
- R6: The reserved code `speed_sel`=11 holds `frame_clk` and `bit_clk` at 0 and sets `cfg_err`, in master and in slave operation. A later valid code clears `cfg_err` and restarts the clocks.
- R7: Counting starts at the first rising `mclk` edge that samples a `speed_sel`, `halve_en` or `master_sel` value differing from the one in use. The first rising edge after reset also starts the count. Call that edge 0; after edge k the frame position is k. The first frame after any change therefore has full length.
- R8: With `master_sel`=0 (and a valid speed code), `frame_clk` and `bit_clk` follow `ext_frame_clk` and `ext_bit_clk` combinationally, and `frame_start` is 0. `cfg_err` equals `halve_en`, and the prescaler has no other effect.
- R9: While `rst_n` is 0, all four outputs are 0 whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset and power-down |
| speed_sel | input | 2 | Speed code: 00 single, 01 double, 10 quad, 11 reserved |
| halve_en | input | 1 | Halve the master clock before the dividers |
| master_sel | input | 1 | 1 = generate clocks, 0 = pass external clocks |
| ext_frame_clk | input | 1 | Frame clock supplied from outside in slave operation |
| ext_bit_clk | input | 1 | Bit clock supplied from outside in slave operation |
| frame_clk | output | 1 | Frame (left/right) clock |
| bit_clk | output | 1 | Serial bit clock |
| frame_start | output | 1 | High for the first internal cycle of each frame |
| cfg_err | output | 1 | Reserved code or prescaler requested in slave operation |

## Verification
A frame-clock transition and a bit-clock falling edge must occur in the same master-clock cycle. The divider restart after a configuration change must also coincide with the frame-start strobe. Random configuration changes are applied at arbitrary points inside a frame, so a restart often lands in the same cycle as a scheduled frame-clock edge. Each cycle the bench compares the outputs with the frame position counted from the last change. It also checks that every frame-clock transition it sees comes with a 1-to-0 step of the bit clock.

// File: rtl/audio_clkgen.sv
`timescale 1ns/1ps
module audio_clkgen (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic [1:0] speed_sel,
  input  logic       halve_en,
  input  logic       master_sel,
  input  logic       ext_frame_clk,
  input  logic       ext_bit_clk,
  output logic       frame_clk,
  output logic       bit_clk,
  output logic       frame_start,
  output logic       cfg_err
);
  localparam int CW = 9;
  localparam logic [CW-1:0] ONE = 1;

  logic [CW-1:0] pos;
  logic [1:0]    spd_q;
  logic          half_q, mst_q, loaded_q;

  wire cfg_new = !loaded_q || speed_sel != spd_q || halve_en != half_q || master_sel != mst_q;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      spd_q    <= 2'b00;
      half_q   <= 1'b0;
      mst_q    <= 1'b0;
      loaded_q <= 1'b0;
    end else if (cfg_new) begin
      pos      <= '0;
      spd_q    <= speed_sel;
      half_q   <= halve_en;
      mst_q    <= master_sel;
      loaded_q <= 1'b1;
    end else begin
      pos <= pos + ONE;
    end
  end

  wire       reserved = loaded_q && spd_q == 2'b11;
  wire       pre      = half_q & mst_q;
  wire       run      = loaded_q && mst_q && !reserved;
  wire [3:0] frame_lg = 4'd8 - {2'b00, spd_q} + {3'b000, pre};
  wire [3:0] bit_lg   = frame_lg - 4'd6;
  wire       direct   = run && bit_lg == 4'd0;

  wire [CW-1:0] fsh       = pos >> (frame_lg - 4'd1);
  wire [CW-1:0] bsh       = pos >> (bit_lg - 4'd1);
  wire [CW-1:0] frame_pos = pos & ((ONE << frame_lg) - ONE);

  wire gen_frame = run & fsh[0];
  wire gen_bit   = run & bsh[0];

  assign frame_clk   = (!loaded_q || reserved) ? 1'b0 :
                       mst_q ? gen_frame : ext_frame_clk;
  assign bit_clk     = (!loaded_q || reserved) ? 1'b0 :
                       !mst_q ? ext_bit_clk :
                       direct ? ~mclk : gen_bit;
  assign frame_start = run && (frame_pos >> pre) == '0;
  assign cfg_err     = loaded_q && (reserved || (!mst_q && half_q));
endmodule

module audio_clkgen_chk (
  input logic       mclk,
  input logic       rst_n,
  input logic [1:0] speed_sel,
  input logic       halve_en,
  input logic       master_sel,
  input logic       ext_frame_clk,
  input logic       ext_bit_clk,
  input logic       frame_clk,
  input logic       bit_clk,
  input logic       frame_start,
  input logic       cfg_err
);
  logic [1:0] spd_d1, spd_d2, since;
  logic       half_d1, half_d2, mst_d1, mst_d2;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      spd_d1 <= 2'b00; spd_d2 <= 2'b00;
      half_d1 <= 1'b0; half_d2 <= 1'b0;
      mst_d1 <= 1'b0;  mst_d2 <= 1'b0;
      since <= 2'd0;
    end else begin
      spd_d1 <= speed_sel;  spd_d2 <= spd_d1;
      half_d1 <= halve_en;  half_d2 <= half_d1;
      mst_d1 <= master_sel; mst_d2 <= mst_d1;
      if (since != 2'd3) since <= since + 2'd1;
    end
  end

  wire same_cfg  = spd_d1 == spd_d2 && half_d1 == half_d2 && mst_d1 == mst_d2;
  wire gen_valid = mst_d1 && spd_d1 != 2'b11;
  wire counted_bit = !(spd_d1 == 2'b10 && !half_d1);

  assert_frame_on_bit_fall_R4: assert property (@(posedge mclk) disable iff (!rst_n)
    (since >= 2'd2 && same_cfg && gen_valid && counted_bit && frame_clk != $past(frame_clk))
      |-> (!bit_clk && $past(bit_clk)));

  assert_strobe_in_low_half_R5: assert property (@(posedge mclk) disable iff (!rst_n)
    frame_start |-> !frame_clk);

  assert_reserved_quiet_R6: assert property (@(posedge mclk) disable iff (!rst_n)
    (since >= 2'd1 && spd_d1 == 2'b11) |-> (!frame_clk && !bit_clk && cfg_err && !frame_start));

  assert_restart_full_frame_R7: assert property (@(posedge mclk) disable iff (!rst_n)
    (since >= 2'd1 && gen_valid && (since == 2'd1 || !same_cfg)) |-> (frame_start && !frame_clk));

  assert_slave_pass_R8: assert property (@(posedge mclk) disable iff (!rst_n)
    (since >= 2'd1 && !mst_d1 && spd_d1 != 2'b11)
      |-> (frame_clk == ext_frame_clk && bit_clk == ext_bit_clk && !frame_start && cfg_err == half_d1));

  always @(negedge mclk) begin
    if (rst_n === 1'b0) begin
      assert_reset_quiet_R9: assert (!frame_clk && !bit_clk && !frame_start && !cfg_err)
        else $error("outputs not quiet during reset");
    end
  end
endmodule

bind audio_clkgen audio_clkgen_chk i_chk (.*);

// File: tb/test_audio_clkgen.sv
`timescale 1ns/1ps
module test_audio_clkgen;
  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] speed_sel = 2'b00;
  logic       halve_en = 1'b0;
  logic       master_sel = 1'b1;
  logic       ext_frame_clk = 1'b0;
  logic       ext_bit_clk = 1'b0;
  logic       frame_clk, bit_clk, frame_start, cfg_err;

  audio_clkgen i_audio_clkgen (.*);

  always #5 mclk = ~mclk;

  int checks = 0;
  int errors = 0;
  int kk = 0;
  logic prev_frame = 1'b0, prev_bit = 1'b0;

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b (pos %0d)", req, what, act, exp, kk);
    end
  endtask

  function automatic int frame_len(logic [1:0] s, logic h);
    return (256 >> s) << h;
  endfunction

  function automatic logic exp_frame(int k, int n);
    return (k % n) >= n / 2;
  endfunction

  function automatic logic exp_bit(int k, int n);
    int b = n / 64;
    return (b == 1) ? 1'b0 : ((k % b) >= b / 2);
  endfunction

  function automatic logic exp_start(int k, int n, logic h);
    return (k % n) < (h ? 2 : 1);
  endfunction

  task automatic set_cfg(logic [1:0] s, logic h, logic m);
    @(negedge mclk);
    if (s != speed_sel || h != halve_en || m != master_sel) kk = -1;
    speed_sel = s; halve_en = h; master_sel = m;
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge mclk);
      kk++;
      if (!master_sel) begin
        ext_frame_clk = 1'($urandom);
        ext_bit_clk   = 1'($urandom);
      end
      #2;
      if (speed_sel == 2'b11) begin
        chk("R6", "frame_clk", frame_clk, 1'b0);
        chk("R6", "bit_clk", bit_clk, 1'b0);
        chk("R6", "cfg_err", cfg_err, 1'b1);
      end else if (!master_sel) begin
        chk("R8", "frame_clk", frame_clk, ext_frame_clk);
        chk("R8", "bit_clk", bit_clk, ext_bit_clk);
        chk("R8", "frame_start", frame_start, 1'b0);
        chk("R8", "cfg_err", cfg_err, halve_en);
      end else begin
        int n_len = frame_len(speed_sel, halve_en);
        chk(halve_en ? "R3" : "R1", "frame_clk", frame_clk, exp_frame(kk, n_len));
        chk(halve_en ? "R3" : "R2", "bit_clk", bit_clk, exp_bit(kk, n_len));
        chk(kk == 0 ? "R7" : "R5", "frame_start", frame_start, exp_start(kk, n_len, halve_en));
        chk("R6", "cfg_err", cfg_err, 1'b0);
        if (kk >= 1 && n_len / 64 > 1 && frame_clk != prev_frame)
          chk("R4", "bit fall at frame edge", prev_bit & ~bit_clk, 1'b1);
        prev_frame = frame_clk;
        prev_bit   = bit_clk;
        if (n_len == 64) begin
          #5;
          chk("R2", "direct bit_clk low phase", bit_clk, 1'b1);
        end
      end
    end
  endtask

  initial begin
    #1_900_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    master_sel = 1'b0; halve_en = 1'b1; ext_frame_clk = 1'b1; ext_bit_clk = 1'b1;
    repeat (3) @(posedge mclk);
    #2;
    chk("R9", "frame_clk", frame_clk, 1'b0);
    chk("R9", "bit_clk", bit_clk, 1'b0);
    chk("R9", "frame_start", frame_start, 1'b0);
    chk("R9", "cfg_err", cfg_err, 1'b0);

    @(negedge mclk);
    master_sel = 1'b1; halve_en = 1'b0; speed_sel = 2'b00;
    rst_n = 1'b1; kk = -1;
    run_cycles(600);

    for (int s = 0; s < 3; s++)
      for (int h = 0; h < 2; h++) begin
        set_cfg(2'(s), 1'(h), 1'b1);
        run_cycles(2 * frame_len(2'(s), 1'(h)) + 3);
      end

    set_cfg(2'b11, 1'b0, 1'b1);
    run_cycles(20);
    set_cfg(2'b10, 1'b0, 1'b1);
    run_cycles(100);
    set_cfg(2'b11, 1'b1, 1'b0);
    run_cycles(10);
    set_cfg(2'b01, 1'b1, 1'b0);
    run_cycles(30);
    set_cfg(2'b01, 1'b0, 1'b0);
    run_cycles(10);

    set_cfg(2'b00, 1'b0, 1'b1);
    run_cycles(77);
    @(negedge mclk);
    rst_n = 1'b0;
    #1;
    chk("R9", "frame_clk mid-run", frame_clk, 1'b0);
    chk("R9", "frame_start mid-run", frame_start, 1'b0);
    @(negedge mclk);
    rst_n = 1'b1; kk = -1;
    run_cycles(300);

    for (int it = 0; it < 30; it++) begin
      logic [1:0] s = 2'($urandom % 4);
      logic h = 1'($urandom);
      logic m = ($urandom % 4) != 0;
      set_cfg(s, h, m);
      run_cycles(int'($urandom % 600) + 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule